// File: doc/BRIEF.md
# Packet capture buffer with overflow truncation

This block sits between a bus packet filter and a host-side reader. It stores each packet it accepts as a record in a small on-chip FIFO. A record is one header word followed by one word per stored payload byte. The reader drains records one word at a time with a show-ahead valid/acknowledge pair. Capture is armed by a rising edge on the enable input and always stops on a packet boundary. It also stops by itself when the next record cannot fit. After it stops, the reader can still drain everything stored, and then it sees an end-of-capture flag.

There are three modes. Plain streaming lets the reader drain while capture runs. Guarded streaming adds hysteresis-based truncation: when the buffer is at or above a high mark, long payloads are cut to their first four bytes. The header still carries the real length and a truncation tag. Deferred download hides all data from the reader until capture has stopped.

The filter presents each packet as one header beat followed by exactly as many byte beats as the length given on the header beat. There is no back-pressure.

Top module: `cap_buffer`

## Requirements
- R1: After reset, `rd_valid` and `cap_eoc` are low.
- R2: In plain streaming mode (`mode`=0), records written during a running capture are readable at once: `rd_valid` is high while the FIFO holds data, and words come out in write order.
- R3: The header word layout is as follows.
  - Bit 15 is the truncation tag and bit 14 is always 1.
  - Bits 13:8 hold the true packet length and bits 7:0 hold the timestamp given on the header beat.
  - Each payload word is `{8'h00, byte}`.
  - A packet of length 0 produces a lone header.
- R4: A header beat is accepted only if the whole record (header plus stored bytes) fits in the free space. If it does not fit, the packet is dropped and capture stops. Later packets are ignored until a new enable rising edge, while the stored words can still be drained.
- R5: `cap_eoc` is high exactly when capture has stopped and the FIFO is empty. It drops when a new capture starts.
- R6: Lowering `cap_en` while a packet is being stored lets that packet finish whole. Capture then stops, and a later header beat is ignored.
- R7: In guarded mode (`mode`=1), a packet longer than 4 bytes whose header beat sees truncation active stores only its first 4 bytes. Its header has the tag bit set and the true length. Truncation becomes active at a header beat when the fill (in words, before that header is written) is at least `hi_mark`.
- R8: A packet of 4 bytes or fewer is always stored whole with the tag bit clear, and it still updates the truncation state.
- R9: Once active, truncation remains active at later header beats until a header beat sees the fill below `lo_mark`.
- R10: In plain streaming and deferred modes, no packet is ever truncated, whatever the marks.
- R11: In deferred mode (`mode`=2), `rd_valid` stays low while capture runs. All stored words become readable after capture stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_en | input | 1 | Capture enable; a rising edge starts a capture, low requests a stop at the next packet boundary |
| mode | input | 2 | 0 plain streaming, 1 guarded streaming, 2 deferred download, 3 as 0 |
| hi_mark | input | AW+1 (6) | Fill level (words) at or above which truncation starts |
| lo_mark | input | AW+1 (6) | Fill level (words) below which truncation ends |
| in_valid | input | 1 | Input beat valid |
| in_sop | input | 1 | Beat is a header beat carrying length and timestamp |
| in_len | input | LEN_W (6) | True packet length in bytes, on header beats |
| in_ts | input | TS_W (8) | Packet timestamp, on header beats |
| in_byte | input | 8 | Payload byte, on data beats |
| rd_ack | input | 1 | Reader consumes the word shown on `rd_data` |
| rd_valid | output | 1 | A word is available to the reader |
| rd_data | output | W (16) | Oldest stored word |
| cap_eoc | output | 1 | End of capture: stopped and fully drained |

## Verification
A wrong fill count or pointer shows up at the ports as a wrong word or a missing `rd_valid`. It appears when that word is drained, or at the next header beat as a wrong admission or wrong truncation decision. A wrong truncation latch therefore appears one record later, as a tag bit and a stored payload length that disagree with the fill history the bench computes. A stuck capture state shows as `cap_eoc` failing to rise after the last word is read, or as a packet stored after a stop.

// File: rtl/cap_pkg.sv
// Shared types for the capture buffer.
// Assumes: mode encodings are fixed by the block's external contract.
package cap_pkg;
    typedef enum logic [1:0] {
        MODE_STREAM = 2'd0,
        MODE_GUARD  = 2'd1,
        MODE_DEFER  = 2'd2,
        MODE_ALT    = 2'd3
    } cap_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_STOP = 2'd2
    } cap_state_e;
endpackage

// File: rtl/cap_mem.sv
// Word FIFO holding capture records, with show-ahead read and a fill count.
// Assumes: DEPTH is a power of two; the writer never writes when full.
module cap_mem #(
    parameter int DEPTH = 32,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_pop,
    output logic [W-1:0]  rd_data,
    output logic          empty,
    output logic [AW:0]   fill
);
    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic          do_pop;

    assign empty   = (fill == '0);
    assign do_pop  = rd_pop && !empty;
    assign rd_data = store[rptr];

    // Storage array write port.
    always_ff @(posedge clk) begin
        if (wr_en) store[wptr] <= wr_data;
    end

    // Pointer and fill-count upkeep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (wr_en)  wptr <= wptr + 1'b1;
            if (do_pop) rptr <= rptr + 1'b1;
            case ({wr_en, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(fill) < DEPTH));
endmodule

// File: rtl/cap_trunc.sv
// Hysteresis latch deciding whether payloads are being truncated.
// Assumes: the marks satisfy lo < hi; the decision strobe fires once per header.
module cap_trunc #(
    parameter int FW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          guard_on,
    input  logic          decide,
    input  logic [FW-1:0] fill,
    input  logic [FW-1:0] hi_mark,
    input  logic [FW-1:0] lo_mark,
    output logic          trunc_now
);
    logic trunc_q;

    assign trunc_now = guard_on && ((fill >= hi_mark) || (trunc_q && (fill >= lo_mark)));

    // Latch the decision at each header; cleared outside guarded mode.
    always_ff @(posedge clk) begin
        if (!rst_n)        trunc_q <= 1'b0;
        else if (!guard_on) trunc_q <= 1'b0;
        else if (decide)   trunc_q <= trunc_now;
    end
endmodule

// File: rtl/cap_ctrl.sv
// Capture state machine and record writer: admits whole records, builds
// headers, drops truncated bytes, and stops on full or on a disable request.
// Assumes: each header beat is followed by exactly in_len data beats.
module cap_ctrl
    import cap_pkg::*;
#(
    parameter int DEPTH       = 32,
    parameter int LEN_W       = 6,
    parameter int TS_W        = 8,
    parameter int TRUNC_BYTES = 4,
    localparam int AW         = $clog2(DEPTH),
    localparam int W          = 2 + LEN_W + TS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic             guard_on,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic [LEN_W-1:0] in_len,
    input  logic [TS_W-1:0]  in_ts,
    input  logic [7:0]       in_byte,
    input  logic [AW:0]      fill,
    input  logic             trunc_now,
    output logic             decide,
    output logic             wr_en,
    output logic [W-1:0]     wr_data,
    output logic             running,
    output logic             stopped
);
    cap_state_e       state;
    logic             en_q;
    logic             in_pkt_q;
    logic [LEN_W-1:0] idx_q;
    logic [LEN_W-1:0] slen_q;
    logic [LEN_W-1:0] rem_q;
    logic             rise;
    logic             cut;
    logic [LEN_W-1:0] slen;
    logic             fits;
    logic             accept;
    logic             full_stop;
    logic             data_beat;
    logic             store_byte;

    assign rise       = cap_en && !en_q;
    assign decide     = in_valid && in_sop && (state == ST_RUN) && cap_en && !in_pkt_q;
    assign cut        = guard_on && trunc_now && (int'(in_len) > TRUNC_BYTES);
    assign slen       = cut ? LEN_W'(TRUNC_BYTES) : in_len;
    assign fits       = (DEPTH - int'(fill)) >= (int'(slen) + 1);
    assign accept     = decide && fits;
    assign full_stop  = decide && !fits;
    assign data_beat  = in_valid && !in_sop && in_pkt_q;
    assign store_byte = data_beat && (idx_q < slen_q);
    assign wr_en      = accept || store_byte;
    assign wr_data    = accept ? {cut, 1'b1, in_len, in_ts} : {{(W-8){1'b0}}, in_byte};
    assign running    = (state == ST_RUN);
    assign stopped    = (state == ST_STOP);

    // Capture state: start on enable rise, stop on full or at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            en_q  <= 1'b0;
        end else begin
            en_q <= cap_en;
            case (state)
                ST_RUN: begin
                    if (full_stop)                  state <= ST_STOP;
                    else if (!cap_en && !in_pkt_q)  state <= ST_STOP;
                end
                default: if (rise) state <= ST_RUN;
            endcase
        end
    end

    // Per-packet byte tracking for the record being stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pkt_q <= 1'b0;
            idx_q    <= '0;
            slen_q   <= '0;
            rem_q    <= '0;
        end else if (accept) begin
            in_pkt_q <= (in_len != '0);
            idx_q    <= '0;
            slen_q   <= slen;
            rem_q    <= in_len;
        end else if (data_beat) begin
            idx_q <= idx_q + 1'b1;
            rem_q <= rem_q - 1'b1;
            if (rem_q == LEN_W'(1)) in_pkt_q <= 1'b0;
        end
    end

    // R6
    boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && in_pkt_q) |=> running);

    // R4
    stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && cap_en && en_q) |=> stopped);

    // R8
    short_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (int'(in_len) <= TRUNC_BYTES)) |-> !wr_data[W-1]);
endmodule

// File: rtl/cap_buffer.sv
// Top of the packet capture buffer: record writer, truncation latch and FIFO,
// with read gating for deferred download and the end-of-capture flag.
// Assumes: hi_mark > lo_mark; mode is changed only while capture is not running.
module cap_buffer
    import cap_pkg::*;
#(
    parameter int DEPTH       = 32,
    parameter int LEN_W       = 6,
    parameter int TS_W        = 8,
    parameter int TRUNC_BYTES = 4,
    localparam int AW         = $clog2(DEPTH),
    localparam int W          = 2 + LEN_W + TS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [1:0]       mode,
    input  logic [AW:0]      hi_mark,
    input  logic [AW:0]      lo_mark,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic [LEN_W-1:0] in_len,
    input  logic [TS_W-1:0]  in_ts,
    input  logic [7:0]       in_byte,
    input  logic             rd_ack,
    output logic             rd_valid,
    output logic [W-1:0]     rd_data,
    output logic             cap_eoc
);
    cap_mode_e       mode_e;
    logic            guard_on;
    logic            decide;
    logic            trunc_now;
    logic            wr_en;
    logic [W-1:0]    wr_data;
    logic            running;
    logic            stopped;
    logic            empty;
    logic [AW:0]     fill;
    logic            pop;

    assign mode_e   = cap_mode_e'(mode);
    assign guard_on = (mode_e == MODE_GUARD);
    assign rd_valid = !empty && !((mode_e == MODE_DEFER) && running);
    assign pop      = rd_ack && rd_valid;
    assign cap_eoc  = stopped && empty;

    cap_ctrl #(
        .DEPTH(DEPTH), .LEN_W(LEN_W), .TS_W(TS_W), .TRUNC_BYTES(TRUNC_BYTES)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .guard_on(guard_on),
        .in_valid(in_valid), .in_sop(in_sop), .in_len(in_len), .in_ts(in_ts),
        .in_byte(in_byte), .fill(fill), .trunc_now(trunc_now), .decide(decide),
        .wr_en(wr_en), .wr_data(wr_data), .running(running), .stopped(stopped)
    );

    cap_trunc #(.FW(AW + 1)) trunc_i (
        .clk(clk), .rst_n(rst_n), .guard_on(guard_on), .decide(decide),
        .fill(fill), .hi_mark(hi_mark), .lo_mark(lo_mark), .trunc_now(trunc_now)
    );

    cap_mem #(.DEPTH(DEPTH), .W(W)) mem_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_pop(pop), .rd_data(rd_data), .empty(empty), .fill(fill)
    );

    // R10
    no_trunc_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[W-2] && !guard_on) |-> !wr_data[W-1]);

    // R11
    defer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && (mode_e == MODE_DEFER)) |-> !running);

    // R5
    eoc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_eoc |-> !rd_valid);
endmodule

// File: tb/cap_buffer_tb.sv
// Self-checking bench for cap_buffer: drives packets, keeps an arithmetic
// model of the expected FIFO contents, and drains and compares word by word.
module cap_buffer_tb_top;
    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_en = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [5:0]  hi_mark = 6'd40;
    logic [5:0]  lo_mark = 6'd0;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic [5:0]  in_len = '0;
    logic [7:0]  in_ts = '0;
    logic [7:0]  in_byte = '0;
    logic        rd_ack = 1'b0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        cap_eoc;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;
    int exp_q[$];
    bit mrun = 1'b0;
    bit mtr = 1'b0;

    always #10 clk = ~clk;

    cap_buffer dut_i (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .mode(mode),
        .hi_mark(hi_mark), .lo_mark(lo_mark), .in_valid(in_valid),
        .in_sop(in_sop), .in_len(in_len), .in_ts(in_ts), .in_byte(in_byte),
        .rd_ack(rd_ack), .rd_valid(rd_valid), .rd_data(rd_data), .cap_eoc(cap_eoc)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Model a header beat from the requirements (R4, R7, R8, R9, R10).
    task automatic model_hdr(input int len, input int ts, input int base);
        int f;
        bit trn;
        bit cut;
        int slen;
        if (!mrun) return;
        f = exp_q.size();
        trn = (mode == 2'd1) && ((f >= int'(hi_mark)) || (mtr && (f >= int'(lo_mark))));
        mtr = trn;
        cut = trn && (len > 4);
        slen = cut ? 4 : len;
        if (1 + slen > DEPTH - f) begin
            mrun = 1'b0;
            return;
        end
        exp_q.push_back((int'(cut) << 15) | (1 << 14) | (len << 8) | ts);
        for (int i = 0; i < slen; i++) exp_q.push_back((base + i) & 8'hFF);
    endtask

    task automatic send(input int len, input int ts, input int base, input bit drop_en);
        @(negedge clk);
        in_valid = 1'b1; in_sop = 1'b1; in_len = 6'(len); in_ts = 8'(ts);
        model_hdr(len, ts, base);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (drop_en && i == 0) cap_en = 1'b0;
            in_sop = 1'b0; in_byte = 8'(base + i);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0;
    endtask

    task automatic pop_n(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            int e;
            e = exp_q.pop_front();
            chk(rd_valid == 1'b1, req, int'(rd_valid), 1);
            chk(int'(rd_data) == e, req, int'(rd_data), e);
            rd_ack = 1'b1;
            @(negedge clk);
            rd_ack = 1'b0;
        end
    endtask

    task automatic start(input int m, input int hi, input int lo);
        @(negedge clk);
        cap_en = 1'b0; mode = 2'(m); hi_mark = 6'(hi); lo_mark = 6'(lo); mtr = 1'b0;
        @(negedge clk);
        cap_en = 1'b1; mrun = 1'b1;
        @(negedge clk);
    endtask

    task automatic stop_and_wait;
        @(negedge clk);
        cap_en = 1'b0; mrun = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);
        chk(cap_eoc == 1'b0, "R1 cap_eoc", int'(cap_eoc), 0);

        // R2 R3 plain streaming, drained while capture runs
        start(0, 40, 0);
        send(3, 8'h11, 8'hA0, 1'b0);
        send(0, 8'h22, 8'h00, 1'b0);
        send(10, 8'h33, 8'h50, 1'b0);
        chk(rd_valid == 1'b1, "R2 valid during run", int'(rd_valid), 1);
        pop_n(4, "R3 first record");
        pop_n(1, "R3 empty record");
        chk(cap_eoc == 1'b0, "R5 eoc with data left", int'(cap_eoc), 0);
        pop_n(11, "R2 long record");
        chk(cap_eoc == 1'b0, "R5 eoc while running", int'(cap_eoc), 0);
        stop_and_wait();
        chk(cap_eoc == 1'b1, "R5 eoc after stop", int'(cap_eoc), 1);

        // R6 disable during a packet
        start(0, 40, 0);
        send(6, 8'h44, 8'hC0, 1'b1);
        mrun = 1'b0;
        @(negedge clk);
        send(2, 8'h55, 8'h10, 1'b0);
        pop_n(7, "R6 finished record");
        chk(rd_valid == 1'b0, "R6 later packet ignored", int'(rd_valid), 0);
        chk(cap_eoc == 1'b1, "R6 eoc", int'(cap_eoc), 1);

        // R4 full stop with whole-record admission
        start(0, 40, 0);
        send(10, 8'h01, 8'h00, 1'b0);
        send(10, 8'h02, 8'h20, 1'b0);
        send(10, 8'h03, 8'h40, 1'b0);
        send(1, 8'h04, 8'h60, 1'b0);
        chk(exp_q.size() == 22, "R4 model size", exp_q.size(), 22);
        chk(cap_eoc == 1'b0, "R4 eoc before drain", int'(cap_eoc), 0);
        pop_n(22, "R4 drain after full");
        chk(cap_eoc == 1'b1, "R5 eoc after full drain", int'(cap_eoc), 1);
        chk(rd_valid == 1'b0, "R4 nothing after stop", int'(rd_valid), 0);
        start(0, 40, 0);
        chk(cap_eoc == 1'b0, "R5 eoc cleared on restart", int'(cap_eoc), 0);
        stop_and_wait();

        // R7 R8 R9 guarded mode with hysteresis hi=12 lo=6
        start(1, 12, 6);
        send(8, 8'h61, 8'h00, 1'b0);
        send(8, 8'h62, 8'h10, 1'b0);
        send(8, 8'h63, 8'h20, 1'b0);
        send(3, 8'h64, 8'h30, 1'b0);
        chk(exp_q.size() == 27, "R7 model size", exp_q.size(), 27);
        pop_n(18, "R7 whole before mark");
        pop_n(2, "R7 truncated record");
        send(8, 8'h65, 8'h40, 1'b0);
        pop_n(7, "R8 short kept whole");
        pop_n(5, "R9 truncation holds above low mark");
        send(8, 8'h66, 8'h50, 1'b0);
        pop_n(9, "R9 truncation released below low mark");
        stop_and_wait();
        chk(cap_eoc == 1'b1, "R5 eoc guarded", int'(cap_eoc), 1);

        // R10 plain mode ignores low marks
        start(0, 2, 1);
        send(8, 8'h71, 8'h80, 1'b0);
        send(8, 8'h72, 8'h90, 1'b0);
        pop_n(18, "R10 plain never truncates");
        stop_and_wait();

        // R11 R10 deferred download
        start(2, 2, 1);
        send(8, 8'h81, 8'hA0, 1'b0);
        send(5, 8'h82, 8'hB0, 1'b0);
        chk(rd_valid == 1'b0, "R11 hidden while running", int'(rd_valid), 0);
        chk(cap_eoc == 1'b0, "R11 no eoc while running", int'(cap_eoc), 0);
        stop_and_wait();
        pop_n(15, "R11 drain after stop");
        chk(cap_eoc == 1'b1, "R11 eoc after drain", int'(cap_eoc), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule